// File: doc/BRIEF.md
# SDRAM Four-Bank Command Arbiter

This block converts a stream of single-beat memory requests into legal commands for the control pins of a four-bank SDRAM. Each request names a bank, a row, a column and a direction. The block keeps a table of which banks are open and which row each one holds. On a row hit it issues the read or write at once. On a miss it closes the bank and reopens it on the new row. On an idle bank it opens the bank first. Banks are left open after an access, so traffic that stays in one row, or moves between rows already open in different banks, needs no extra commands.

Every spacing rule is a cycle count set by a parameter:
- the delay from opening a bank to its first access;
- the minimum distance between two opens of the same bank;
- the minimum distance between opens of any two banks;
- the longest time a bank may stay open.

A bank that nears the last limit is closed ahead of any pending request. The request port uses a valid/ready handshake. A request transfers only on the edge where its read or write command is issued, and the command bus is registered. Refresh, power-up sequencing, burst counting and the data path are handled elsewhere.

Top module: `sdram_bank_arb`

## Requirements
- R1: While reset is low, and on the first cycle after it, the bus shows NOP ({cs_n,ras_n,cas_n,we_n} = 0111), `req_ready` is low and every bank is treated as closed.
- R2: A request to a closed bank first causes an activate ({cs_n,ras_n,cas_n,we_n} = 0011), with the bank on `sd_ba` and the row on the low bits of `sd_addr`. No read or write goes to a bank that is not open.
- R3: A read or write is issued no fewer than T_RCD cycles after the activate of its bank. When nothing else is pending it comes exactly T_RCD cycles after that activate.
- R4: Two activates of the same bank are at least T_RC cycles apart. A reopen after a row miss is held back until exactly that point.
- R5: Two activates to any banks are at least T_RRD cycles apart.
- R6: An open bank is precharged before T_RAS_MAX cycles have passed since its activate. With no other bank due, the forced precharge comes exactly T_RAS_MAX − NUM_BANKS cycles after the activate, and it takes priority over any request.
- R7: A request to an open bank holding a different row causes a precharge of that bank ({cs_n,ras_n,cas_n,we_n} = 0010, `sd_addr[10]` low, bank on `sd_ba`), followed by an activate of the new row.
- R8: A read is {cs_n,ras_n,cas_n,we_n} = 0101 and a write is 0100. Both carry the column on the low bits of `sd_addr`, with `sd_addr[10]` low.
- R9: `req_ready` is high only while `req_valid` is high, and only in the cycle whose edge issues that request's read or write. Row hits presented back to back issue on consecutive cycles.
- R10: With no request pending and no bank due, the bus shows NOP. An open bank is not precharged except on a row miss or under R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | Request transfers at this edge (its read/write issues) |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column |
| req_write | input | 1 | 1 = write, 0 = read |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Row or column address; bit 10 low on precharge and access |

## Verification
The bench measures the exact cycle distances between commands. A design that counts its delays from the wrong edge shows up as a read one cycle early or late after an activate. A design with a missing same-bank timer shows up as a reopen after a row miss that comes too soon, and one that ignores the cross-bank spacing shows up as two activates to different banks issued too close together. The bench leaves banks open while no requests arrive. This catches a design that never closes them before the open-time limit, and also one that closes them early or without cause. Back-to-back row hits check that a design does not insert idle cycles or reopen a bank that is already open. Four banks opened in quick succession check that forced closes still arrive in time when several banks come due close together.

// File: rtl/sdram_arb_pkg.sv
package sdram_arb_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_NOP = 4'b0111,
      CMD_ACT = 4'b0011,
      CMD_RD  = 4'b0101,
      CMD_WR  = 4'b0100,
      CMD_PRE = 4'b0010
   } sd_cmd_e;

endpackage

// File: rtl/sdram_gap_timer.sv
// Down-counter that reports when T cycles have elapsed since the last load.
module sdram_gap_timer #(
   parameter int T = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic done
);
   localparam int W = (T < 2) ? 1 : $clog2(T + 1);

   if (T < 1) begin : g_bad_t
      $error("sdram_gap_timer: T must be at least 1");
   end

   logic [W-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         left_q <= '0;
      else if (load)
         left_q <= W'(T - 1);
      else if (left_q != '0)
         left_q <= left_q - 1'b1;
   end

   assign done = (left_q == '0);
endmodule

// File: rtl/sdram_bank_state.sv
// One bank: open flag, open row, access / reopen timers and open-time limit.
module sdram_bank_state #(
   parameter int ROW_W     = 12,
   parameter int T_RCD     = 3,
   parameter int T_RC      = 9,
   parameter int T_RAS_MAX = 64,
   parameter int MARGIN    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_en,
   input  logic             pre_en,
   input  logic [ROW_W-1:0] act_row,
   output logic             active,
   output logic [ROW_W-1:0] open_row,
   output logic             rcd_ok,
   output logic             rc_ok,
   output logic             urgent
);
   localparam int RW = $clog2(T_RAS_MAX);

   logic          active_q;
   logic [ROW_W-1:0] row_q;
   logic [RW-1:0] ras_left_q;

   sdram_gap_timer #(.T(T_RCD)) u_rcd (
      .clk(clk), .rst_n(rst_n), .load(act_en), .done(rcd_ok)
   );

   sdram_gap_timer #(.T(T_RC)) u_rc (
      .clk(clk), .rst_n(rst_n), .load(act_en), .done(rc_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q   <= 1'b0;
         row_q      <= '0;
         ras_left_q <= '0;
      end else begin
         if (act_en) begin
            active_q   <= 1'b1;
            row_q      <= act_row;
            ras_left_q <= RW'(T_RAS_MAX - 1);
         end else begin
            if (pre_en)
               active_q <= 1'b0;
            if (ras_left_q != '0)
               ras_left_q <= ras_left_q - 1'b1;
         end
      end
   end

   assign active   = active_q;
   assign open_row = row_q;
   assign urgent   = active_q && (ras_left_q <= RW'(MARGIN));
endmodule

// File: rtl/sdram_cmd_pick.sv
// Chooses the single command for this cycle from the bank table and the request.
module sdram_cmd_pick
   import sdram_arb_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 2,
   parameter int ROW_W     = 12,
   parameter int COL_W     = 9,
   parameter int ADDR_W    = 12
) (
   input  logic                             req_valid,
   input  logic [BANK_W-1:0]                req_bank,
   input  logic [ROW_W-1:0]                 req_row,
   input  logic [COL_W-1:0]                 req_col,
   input  logic                             req_write,
   input  logic [NUM_BANKS-1:0]             active,
   input  logic [NUM_BANKS-1:0][ROW_W-1:0]  open_row,
   input  logic [NUM_BANKS-1:0]             rcd_ok,
   input  logic [NUM_BANKS-1:0]             rc_ok,
   input  logic [NUM_BANKS-1:0]             urgent,
   input  logic                             rrd_ok,
   output sd_cmd_e                          cmd,
   output logic [BANK_W-1:0]                cmd_bank,
   output logic [ADDR_W-1:0]                cmd_addr,
   output logic                             ready,
   output logic [NUM_BANKS-1:0]             act_vec,
   output logic [NUM_BANKS-1:0]             pre_vec
);
   logic              urg_found;
   logic [BANK_W-1:0] urg_idx;

   always_comb begin
      urg_found = 1'b0;
      urg_idx   = '0;
      for (int i = NUM_BANKS - 1; i >= 0; i--) begin
         if (urgent[i]) begin
            urg_found = 1'b1;
            urg_idx   = BANK_W'(i);
         end
      end
   end

   always_comb begin
      cmd      = CMD_NOP;
      cmd_bank = '0;
      cmd_addr = '0;
      ready    = 1'b0;
      act_vec  = '0;
      pre_vec  = '0;
      if (urg_found) begin
         cmd              = CMD_PRE;
         cmd_bank         = urg_idx;
         pre_vec[urg_idx] = 1'b1;
      end else if (req_valid) begin
         if (active[req_bank]) begin
            if (open_row[req_bank] == req_row) begin
               if (rcd_ok[req_bank]) begin
                  cmd      = req_write ? CMD_WR : CMD_RD;
                  cmd_bank = req_bank;
                  cmd_addr = ADDR_W'(req_col);
                  ready    = 1'b1;
               end
            end else begin
               cmd               = CMD_PRE;
               cmd_bank          = req_bank;
               pre_vec[req_bank] = 1'b1;
            end
         end else if (rc_ok[req_bank] && rrd_ok) begin
            cmd               = CMD_ACT;
            cmd_bank          = req_bank;
            cmd_addr          = ADDR_W'(req_row);
            act_vec[req_bank] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/sdram_bank_arb.sv
module sdram_bank_arb
   import sdram_arb_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 12,
   parameter int COL_W     = 9,
   parameter int ADDR_W    = 12,
   parameter int T_RCD     = 3,
   parameter int T_RC      = 9,
   parameter int T_RRD     = 2,
   parameter int T_RAS_MAX = 64,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   input  logic              req_write,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [BANK_W-1:0] sd_ba,
   output logic [ADDR_W-1:0] sd_addr
);
   localparam int MARGIN = NUM_BANKS;

   if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
      $error("sdram_bank_arb: NUM_BANKS must be a power of two, at least 2");
   end
   if (ADDR_W < 11 || ROW_W > ADDR_W || COL_W > 10) begin : g_bad_addr
      $error("sdram_bank_arb: address widths leave no room for bit 10");
   end
   if (T_RAS_MAX <= T_RCD + MARGIN + 1) begin : g_bad_ras
      $error("sdram_bank_arb: T_RAS_MAX too short for the forced-close margin");
   end

   logic [NUM_BANKS-1:0]            active, rcd_ok, rc_ok, urgent;
   logic [NUM_BANKS-1:0][ROW_W-1:0] open_row;
   logic [NUM_BANKS-1:0]            act_vec, pre_vec;
   logic                            rrd_ok;
   sd_cmd_e                         cmd;
   logic [BANK_W-1:0]               cmd_bank;
   logic [ADDR_W-1:0]               cmd_addr;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      sdram_bank_state #(
         .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RC(T_RC),
         .T_RAS_MAX(T_RAS_MAX), .MARGIN(MARGIN)
      ) u_bank (
         .clk(clk), .rst_n(rst_n),
         .act_en(act_vec[b]), .pre_en(pre_vec[b]), .act_row(req_row),
         .active(active[b]), .open_row(open_row[b]),
         .rcd_ok(rcd_ok[b]), .rc_ok(rc_ok[b]), .urgent(urgent[b])
      );
   end

   sdram_gap_timer #(.T(T_RRD)) u_rrd (
      .clk(clk), .rst_n(rst_n), .load(|act_vec), .done(rrd_ok)
   );

   sdram_cmd_pick #(
      .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W),
      .COL_W(COL_W), .ADDR_W(ADDR_W)
   ) u_pick (
      .req_valid(req_valid), .req_bank(req_bank), .req_row(req_row),
      .req_col(req_col), .req_write(req_write),
      .active(active), .open_row(open_row), .rcd_ok(rcd_ok),
      .rc_ok(rc_ok), .urgent(urgent), .rrd_ok(rrd_ok),
      .cmd(cmd), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
      .ready(req_ready), .act_vec(act_vec), .pre_vec(pre_vec)
   );

   logic [3:0]        cmd_q;
   logic [BANK_W-1:0] ba_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= CMD_NOP;
         ba_q   <= '0;
         addr_q <= '0;
      end else begin
         cmd_q  <= cmd;
         ba_q   <= cmd_bank;
         addr_q <= cmd_addr;
      end
   end

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
   assign sd_ba   = ba_q;
   assign sd_addr = addr_q;
endmodule

// File: rtl/sdram_arb_chk.sv
// Rebuilds bank state from the command bus alone and checks the spacing rules.
module sdram_arb_chk #(
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 12,
   parameter int T_RCD     = 3,
   parameter int T_RC      = 9,
   parameter int T_RRD     = 2,
   parameter int T_RAS_MAX = 64,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              sd_cs_n,
   input logic              sd_ras_n,
   input logic              sd_cas_n,
   input logic              sd_we_n,
   input logic [BANK_W-1:0] sd_ba,
   input logic [ADDR_W-1:0] sd_addr
);
   localparam int CAP = T_RC + T_RAS_MAX;
   localparam int AW  = $clog2(CAP + 1);

   logic [3:0] bus;
   logic       is_act, is_pre, is_acc;
   assign bus    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
   assign is_act = (bus == 4'b0011);
   assign is_pre = (bus == 4'b0010);
   assign is_acc = (bus == 4'b0101) || (bus == 4'b0100);

   logic [NUM_BANKS-1:0]         open_m;
   logic [NUM_BANKS-1:0][AW-1:0] age;
   logic [AW-1:0]                gap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_m <= '0;
         gap    <= AW'(CAP);
         for (int b = 0; b < NUM_BANKS; b++) age[b] <= AW'(CAP);
      end else begin
         if (is_act) gap <= '0;
         else if (gap < AW'(CAP)) gap <= gap + 1'b1;
         for (int b = 0; b < NUM_BANKS; b++) begin
            if (is_act && sd_ba == BANK_W'(b)) begin
               open_m[b] <= 1'b1;
               age[b]    <= '0;
            end else begin
               if (is_pre && sd_ba == BANK_W'(b)) open_m[b] <= 1'b0;
               if (age[b] < AW'(CAP)) age[b] <= age[b] + 1'b1;
            end
         end
      end
   end

   // R1, R8
   legal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus == 4'b0111) || is_act || is_pre || is_acc);

   // R8
   acc_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_acc || is_pre) |-> !sd_addr[10]);

   // R9
   ready_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> req_valid);

   // R9
   ready_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> is_acc);

   // R5
   rrd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_act |-> (int'(gap) >= T_RRD - 1));

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
      // R2
      act_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (is_act && sd_ba == BANK_W'(b)) |-> !open_m[b]);

      // R2
      acc_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (is_acc && sd_ba == BANK_W'(b)) |-> open_m[b]);

      // R3
      rcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (is_acc && sd_ba == BANK_W'(b)) |-> (int'(age[b]) >= T_RCD - 1));

      // R4
      rc_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (is_act && sd_ba == BANK_W'(b)) |-> (int'(age[b]) >= T_RC - 1));

      // R6
      ras_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
         open_m[b] |-> (int'(age[b]) <= T_RAS_MAX - 2));
   end
endmodule

bind sdram_bank_arb sdram_arb_chk #(
   .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .T_RCD(T_RCD),
   .T_RC(T_RC), .T_RRD(T_RRD), .T_RAS_MAX(T_RAS_MAX)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
   .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
);

// File: tb/sdram_bank_arb_bench.sv
module sdram_bank_arb_bench;
   localparam int NB    = 4;
   localparam int RW    = 12;
   localparam int CW    = 9;
   localparam int AWD   = 12;
   localparam int RCD   = 2;
   localparam int RC    = 10;
   localparam int RRD   = 4;
   localparam int RASX  = 40;
   localparam int LOGN  = 512;

   localparam logic [3:0] C_NOP = 4'b0111;
   localparam logic [3:0] C_ACT = 4'b0011;
   localparam logic [3:0] C_RD  = 4'b0101;
   localparam logic [3:0] C_WR  = 4'b0100;
   localparam logic [3:0] C_PRE = 4'b0010;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [1:0] req_bank = '0;
   logic [RW-1:0] req_row = '0;
   logic [CW-1:0] req_col = '0;
   logic req_write = 1'b0;
   logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [1:0] sd_ba;
   logic [AWD-1:0] sd_addr;

   always #5 clk = ~clk;

   sdram_bank_arb #(
      .NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW), .ADDR_W(AWD),
      .T_RCD(RCD), .T_RC(RC), .T_RRD(RRD), .T_RAS_MAX(RASX)
   ) u_sdram_bank_arb (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
      .req_write(req_write), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
      .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
   );

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;
   int bad_rdy = 0;

   logic [3:0]     lg_cmd [LOGN];
   logic [1:0]     lg_ba  [LOGN];
   logic [AWD-1:0] lg_addr[LOGN];
   int             lg_cyc [LOGN];
   int             lg_n = 0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (req_ready && !req_valid) bad_rdy <= bad_rdy + 1;
         if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != C_NOP && lg_n < LOGN) begin
            lg_cmd[lg_n]  <= {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            lg_ba[lg_n]   <= sd_ba;
            lg_addr[lg_n] <= sd_addr;
            lg_cyc[lg_n]  <= cyc;
            lg_n          <= lg_n + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int find(input int from, input logic [3:0] c, input int b);
      for (int i = from; i < lg_n; i++)
         if (i >= 0 && lg_cmd[i] == c && int'(lg_ba[i]) == b) return i;
      return -1;
   endfunction

   function automatic int cyc_of(input int i);
      return (i >= 0) ? lg_cyc[i] : -1000;
   endfunction

   function automatic int addr_of(input int i);
      return (i >= 0) ? int'(lg_addr[i]) : -1;
   endfunction

   task automatic quiet(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_req(input int b, input int row, input int col, input bit wr);
      @(negedge clk);
      req_valid = 1'b1;
      req_bank  = 2'(b);
      req_row   = RW'(row);
      req_col   = CW'(col);
      req_write = wr;
      #1;
      while (!req_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      #1;
      req_valid = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1 bus NOP in reset",
          int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'(C_NOP));
      chk(req_ready == 1'b0, "R1 ready low in reset", int'(req_ready), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1 bus NOP after reset",
          int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'(C_NOP));
   endtask

   task automatic t_first_access();
      int s, ia, ir;
      s = lg_n;
      do_req(0, 5, 7, 1'b0);
      quiet(3);
      ia = find(s, C_ACT, 0);
      ir = find(s, C_RD, 0);
      chk(ia >= 0 && ia < ir, "R2 activate precedes read", ia, 0);
      chk(addr_of(ia) == 5, "R2 activate carries row", addr_of(ia), 5);
      chk(cyc_of(ir) - cyc_of(ia) == RCD, "R3 read after tRCD",
          cyc_of(ir) - cyc_of(ia), RCD);
      chk(addr_of(ir) == 7, "R8 read column, A10 low", addr_of(ir), 7);
   endtask

   task automatic t_row_hits();
      int s, i1, i2, i3;
      s = lg_n;
      do_req(0, 5, 1, 1'b0);
      do_req(0, 5, 2, 1'b1);
      do_req(0, 5, 3, 1'b0);
      quiet(2);
      i1 = find(s, C_RD, 0);
      i2 = find(s, C_WR, 0);
      i3 = (i1 >= 0) ? find(i1 + 1, C_RD, 0) : -1;
      chk(cyc_of(i2) - cyc_of(i1) == 1, "R9 read then write consecutive",
          cyc_of(i2) - cyc_of(i1), 1);
      chk(cyc_of(i3) - cyc_of(i2) == 1, "R9 write then read consecutive",
          cyc_of(i3) - cyc_of(i2), 1);
      chk(addr_of(i2) == 2, "R8 write code and column", addr_of(i2), 2);
      chk(find(s, C_ACT, 0) == -1, "R9 no reopen on row hit", find(s, C_ACT, 0), -1);
   endtask

   task automatic t_rrd();
      int s, a2, a3;
      s = lg_n;
      do_req(2, 20, 0, 1'b0);
      do_req(3, 30, 0, 1'b0);
      quiet(2);
      a2 = find(s, C_ACT, 2);
      a3 = find(s, C_ACT, 3);
      chk(cyc_of(a3) - cyc_of(a2) == RRD, "R5 cross-bank activate spacing",
          cyc_of(a3) - cyc_of(a2), RRD);
   endtask

   task automatic t_row_miss();
      int s, a1, p, a2, r2;
      s = lg_n;
      do_req(1, 1, 4, 1'b0);
      do_req(1, 2, 4, 1'b0);
      quiet(2);
      a1 = find(s, C_ACT, 1);
      p  = find(s, C_PRE, 1);
      a2 = (a1 >= 0) ? find(a1 + 1, C_ACT, 1) : -1;
      r2 = (a2 >= 0) ? find(a2 + 1, C_RD, 1) : -1;
      chk(cyc_of(p) - cyc_of(a1) == RCD + 1, "R7 precharge right after miss",
          cyc_of(p) - cyc_of(a1), RCD + 1);
      chk(addr_of(p) == 0, "R7 precharge A10 low", addr_of(p), 0);
      chk(cyc_of(a2) - cyc_of(a1) == RC, "R4 reopen after tRC",
          cyc_of(a2) - cyc_of(a1), RC);
      chk(addr_of(a2) == 2, "R7 reopen carries new row", addr_of(a2), 2);
      chk(cyc_of(r2) - cyc_of(a2) == RCD, "R3 read after reopen",
          cyc_of(r2) - cyc_of(a2), RCD);
   endtask

   task automatic t_idle_force();
      int s, a, p;
      s = lg_n;
      do_req(0, 8, 0, 1'b0);
      quiet(45);
      a = find(s, C_ACT, 0);
      p = (a >= 0) ? find(a, C_PRE, 0) : -1;
      chk(cyc_of(p) - cyc_of(a) == RASX - NB, "R6 forced precharge time",
          cyc_of(p) - cyc_of(a), RASX - NB);
      chk(lg_n - s == 3, "R10 no extra commands while idle", lg_n - s, 3);
      chk(bad_rdy == 0, "R9 ready without valid", bad_rdy, 0);
   endtask

   task automatic t_all_banks();
      int s;
      int ai[NB];
      s = lg_n;
      for (int b = 0; b < NB; b++) do_req(b, 10 + b, b, 1'b1);
      quiet(60);
      for (int b = 0; b < NB; b++) begin
         int p;
         ai[b] = find(s, C_ACT, b);
         p = (ai[b] >= 0) ? find(ai[b], C_PRE, b) : -1;
         chk(p >= 0 && cyc_of(p) - cyc_of(ai[b]) < RASX, "R6 every bank closed in time",
             cyc_of(p) - cyc_of(ai[b]), RASX - 1);
      end
      for (int b = 1; b < NB; b++)
         chk(cyc_of(ai[b]) - cyc_of(ai[b-1]) >= RRD, "R5 spacing in a run of opens",
             cyc_of(ai[b]) - cyc_of(ai[b-1]), RRD);
   endtask

   initial begin
      #(10 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      quiet(3);
      t_reset();
      t_first_access();
      t_row_hits();
      quiet(50);
      t_rrd();
      t_row_miss();
      quiet(50);
      t_idle_force();
      quiet(10);
      t_all_banks();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule